// File: doc/BRIEF.md
# Soft Reset Sequencer with Bus-Idle Gating

This block sequences a software-requested reset of a network MAC. Software sets a self-clearing request bit in a control register over a simple single-cycle register bus. The block does not apply the internal reset at once. It waits until the chip's internal bus reports idle, so that no bus transfer is cut off part-way. It then holds the unit in reset for a fixed window, given in clock cycles and of the order of milliseconds in silicon. During that window it asks an external loader to fetch hardware defaults from a serial configuration memory, through a request/done handshake.

While the internal reset is active, the block leaves register accesses unanswered and drives the transmit data lines to zero. It keeps a small set of preserved registers intact. These stand for the address filters, filter tables and descriptor base addresses, which have no default and must survive a soft reset. A power-on reset clears every register, the preserved ones included. A separate disable input turns off the unit's clock enable, holds it in reset and makes it deaf to the bus.

Top module: `mac_srst_ctl`

## Requirements
- R1: Writing a word with bit 0 set to address 0 (control register) while the sequencer is quiet requests a soft reset. The internal reset stays low for as long as `bus_idle_i` is sampled low.
- R2: The internal reset rises in the cycle after the first clock edge that samples `bus_idle_i` high with a request pending. If the reload finishes inside the window, the reset stays high for exactly `RST_CYCLES` cycles.
- R3: `reload_req_o` is high from the start of the reset window until a clock edge samples `reload_done_i` high. The `reload_data_i` word taken at that edge becomes the content of the configuration register at address 1.
- R4: If the reload has not finished when the window expires, the internal reset stays high until the edge that samples `reload_done_i`, then drops in the next cycle.
- R5: While the internal reset is high, and in the single cycle after it drops, bus requests get no acknowledge and writes are ignored.
- R6: Control bit 0 reads 1 while a reset is pending, and reads 0 once the reset completes. Writing 0 to it does not cancel a pending request, and a second request is ignored.
- R7: While the internal reset is high, `tx_data_o` is all zeros. Otherwise it equals `tx_data_i`.
- R8: A soft reset leaves the preserved registers at addresses 2 to 2+PRESV_N-1 unchanged. It clears control bits [DATA_W-1:1], and it clears the configuration register until the reload writes it.
- R9: Power-on reset (`rst_n` low) clears every register, the preserved ones included.
- R10: While `unit_disable_i` is high, `clk_en_o` is 0, the internal reset is high and bus requests get no acknowledge. At the next edge the control and configuration registers clear and any pending reset is dropped. Preserved registers keep their values.
- R11: An accepted access is acknowledged one cycle after the request. A read returns the addressed register, and 0 for an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| unit_disable_i | input | 1 | Unit disable: clock enable off, held in reset |
| bus_idle_i | input | 1 | Internal bus idle indication, sampled synchronously |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_ack_o | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata_o | output | DATA_W | Read data, valid with acknowledge |
| reload_req_o | output | 1 | Request to reload defaults from configuration memory |
| reload_done_i | input | 1 | Reload finished, one-cycle pulse |
| reload_data_i | input | DATA_W | Default value fetched for the configuration register |
| int_rst_o | output | 1 | Internal reset to the rest of the unit |
| clk_en_o | output | 1 | Internal clock enable |
| tx_data_i | input | TX_W | Transmit data from the datapath |
| tx_data_o | output | TX_W | Transmit data to the pins, zero during reset |

## Verification
Two cases are hard to reach from the ports: a reload that finishes after the timer has run out, and a disable that lands while a request waits for the bus. The stimulus holds `bus_idle_i` low so that a request stays parked in the waiting state, then raises the disable. In a separate run it delays `reload_done_i` several cycles past the window. A behavioural model in the bench tracks both paths on every clock. The bench also measures the length of the reset pulse at the ports.

// File: rtl/srst_pkg.sv
// Shared definitions for the soft reset sequencer.
// Assumes: register map is control at 0, configuration at 1, preserved block from 2.
package srst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_RESETTING,
        ST_RELOAD_WAIT,
        ST_DONE
    } srst_state_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_CFG    = 1;
    localparam int ADDR_PRESV0 = 2;
endpackage

// File: rtl/srst_fsm.sv
// Reset sequencer state machine: waits for bus idle, runs the timed window,
// tracks the reload handshake and finishes only when both are complete.
// Assumes: RST_CYCLES >= 2; disable_i synchronous to clk.
module srst_fsm
    import srst_pkg::*;
#(
    parameter int RST_CYCLES = 250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        disable_i,
    input  logic        start_i,
    input  logic        bus_idle_i,
    input  logic        reload_done_i,
    output srst_state_e state_o,
    output logic        reload_req_o,
    output logic        reload_take_o,
    output logic        enter_rst_o,
    output logic        rst_active_o
);
    localparam int TMR_W = $clog2(RST_CYCLES);

    srst_state_e       state_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              seen_q;

    // Reset window covers the timed phase and any wait for a late reload.
    assign rst_active_o  = (state_q == ST_RESETTING) || (state_q == ST_RELOAD_WAIT);
    assign reload_req_o  = rst_active_o && !seen_q && !disable_i;
    assign reload_take_o = reload_req_o && reload_done_i;
    assign enter_rst_o   = (state_q == ST_WAIT_BUS) && bus_idle_i && !disable_i;
    assign state_o       = state_q;

    // State, window timer and reload-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n || disable_i) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) state_q <= ST_WAIT_BUS;
                end
                ST_WAIT_BUS: begin
                    if (bus_idle_i) begin
                        state_q <= ST_RESETTING;
                        tmr_q   <= TMR_W'(RST_CYCLES - 1);
                        seen_q  <= 1'b0;
                    end
                end
                ST_RESETTING: begin
                    if (reload_take_o) seen_q <= 1'b1;
                    if (tmr_q == '0) begin
                        state_q <= (seen_q || reload_take_o) ? ST_DONE : ST_RELOAD_WAIT;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_RELOAD_WAIT: begin
                    if (reload_take_o) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srst_regs.sv
// Register bank behind the single-cycle bus: control, configuration and a
// preserved block. Grants access only while no reset is applied.
// Assumes: ADDR_PRESV0 + PRESV_N <= 2**ADDR_W.
module srst_regs
    import srst_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int PRESV_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disable_i,
    input  srst_state_e       state_i,
    input  logic              enter_rst_i,
    input  logic              reload_take_i,
    input  logic [DATA_W-1:0] reload_data_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              start_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] presv_q [PRESV_N];
    logic [DATA_W-1:0] rd_val;
    logic              acc;
    logic              wr;
    int unsigned       a;

    assign a       = int'(addr_i);
    assign acc     = req_i && !disable_i && (state_i == ST_IDLE || state_i == ST_WAIT_BUS);
    assign wr      = acc && we_i;
    assign start_o = wr && (a == ADDR_CTRL) && wdata_i[0] && (state_i == ST_IDLE);

    // Control register: bit 0 is the self-clearing request, upper bits plain.
    always_ff @(posedge clk) begin
        if (!rst_n || disable_i) begin
            ctrl_q <= '0;
        end else if (enter_rst_i) begin
            ctrl_q <= {{(DATA_W-1){1'b0}}, ctrl_q[0]};
        end else if (state_i == ST_DONE) begin
            ctrl_q[0] <= 1'b0;
        end else if (wr && a == ADDR_CTRL) begin
            ctrl_q <= {wdata_i[DATA_W-1:1], ctrl_q[0] | start_o};
        end
    end

    // Configuration register: cleared by reset, refilled by the reload.
    always_ff @(posedge clk) begin
        if (!rst_n || disable_i || enter_rst_i) begin
            cfg_q <= '0;
        end else if (reload_take_i) begin
            cfg_q <= reload_data_i;
        end else if (wr && a == ADDR_CFG) begin
            cfg_q <= wdata_i;
        end
    end

    // Preserved registers: only power-on reset clears them.
    for (genvar g = 0; g < PRESV_N; g++) begin : g_presv
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                presv_q[g] <= '0;
            end else if (wr && a == ADDR_PRESV0 + g) begin
                presv_q[g] <= wdata_i;
            end
        end
    end

    // Read multiplexer; unmapped addresses read as zero.
    always_comb begin
        rd_val = '0;
        if (a == ADDR_CTRL) rd_val = ctrl_q;
        if (a == ADDR_CFG)  rd_val = cfg_q;
        for (int i = 0; i < PRESV_N; i++) begin
            if (a == ADDR_PRESV0 + i) rd_val = presv_q[i];
        end
    end

    // Acknowledge and read data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o   <= acc;
            rdata_o <= (acc && !we_i) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/mac_srst_ctl.sv
// Top of the soft reset sequencer: joins the state machine and the register
// bank, forms the internal reset and clock enable, and blanks transmit data.
// Assumes: all inputs synchronous to clk.
module mac_srst_ctl #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int PRESV_N    = 4,
    parameter int TX_W       = 8,
    parameter int RST_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_disable_i,
    input  logic              bus_idle_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic              bus_ack_o,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              reload_req_o,
    input  logic              reload_done_i,
    input  logic [DATA_W-1:0] reload_data_i,
    output logic              int_rst_o,
    output logic              clk_en_o,
    input  logic [TX_W-1:0]   tx_data_i,
    output logic [TX_W-1:0]   tx_data_o
);
    srst_pkg::srst_state_e state;
    logic start, take, enter, active;

    srst_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .disable_i    (unit_disable_i),
        .start_i      (start),
        .bus_idle_i   (bus_idle_i),
        .reload_done_i(reload_done_i),
        .state_o      (state),
        .reload_req_o (reload_req_o),
        .reload_take_o(take),
        .enter_rst_o  (enter),
        .rst_active_o (active)
    );

    srst_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESV_N(PRESV_N)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .disable_i    (unit_disable_i),
        .state_i      (state),
        .enter_rst_i  (enter),
        .reload_take_i(take),
        .reload_data_i(reload_data_i),
        .req_i        (bus_req_i),
        .we_i         (bus_we_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .ack_o        (bus_ack_o),
        .rdata_o      (bus_rdata_o),
        .start_o      (start)
    );

    // Internal reset, clock enable and transmit blanking.
    assign int_rst_o = unit_disable_i || active;
    assign clk_en_o  = !unit_disable_i;
    assign tx_data_o = int_rst_o ? '0 : tx_data_i;
endmodule

// File: rtl/srst_chk.sv
// Property checker for the soft reset sequencer, bound to the top module.
// Assumes: RST_CYCLES matches the bound instance.
module srst_chk #(
    parameter int RST_CYCLES = 250000,
    parameter int TX_W       = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            unit_disable_i,
    input logic            bus_idle_i,
    input logic            bus_req_i,
    input logic            bus_ack_o,
    input logic            reload_req_o,
    input logic            int_rst_o,
    input logic            clk_en_o,
    input logic [TX_W-1:0] tx_data_o
);
    int unsigned win_q;

    // Length of the current reset pulse not caused by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !int_rst_o || unit_disable_i) win_q <= 0;
        else                                        win_q <= win_q + 1;
    end

    a_r1_wait_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_rst_o) && !unit_disable_i) |-> $past(bus_idle_i));

    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_rst_o) && !$past(unit_disable_i)) |-> (win_q >= RST_CYCLES));

    a_r3_req_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req_o |-> (int_rst_o && !unit_disable_i));

    a_r5_no_ack_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |=> !bus_ack_o);

    a_r7_tx_blank: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |-> (tx_data_o == '0));

    a_r10_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        unit_disable_i |-> (!clk_en_o && int_rst_o));

    a_r11_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |-> $past(bus_req_i));
endmodule

bind mac_srst_ctl srst_chk #(.RST_CYCLES(RST_CYCLES), .TX_W(TX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .unit_disable_i(unit_disable_i),
    .bus_idle_i    (bus_idle_i),
    .bus_req_i     (bus_req_i),
    .bus_ack_o     (bus_ack_o),
    .reload_req_o  (reload_req_o),
    .int_rst_o     (int_rst_o),
    .clk_en_o      (clk_en_o),
    .tx_data_o     (tx_data_o)
);

// File: tb/mac_srst_ctl_test.sv
// Bench for the soft reset sequencer: behavioural model compared every clock
// plus directed checks at the bus and reset pins.
module mac_srst_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int RST = 24;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        dis = 0;
    logic        idle = 0;
    logic        req = 0;
    logic        we = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic        done_in = 0;
    logic [31:0] rl_data = 0;
    logic [7:0]  tx_in = 0;
    logic        ack, rel_req, int_rst, clk_en;
    logic [31:0] rdata;
    logic [7:0]  tx_out;

    int total = 0;
    int bad = 0;
    int cur_len = 0;
    int last_len = 0;
    bit finished = 0;

    // model state
    int          m_st = 0;
    int          m_tmr = 0;
    bit          m_seen = 0;
    logic [31:0] m_ctrl = 0, m_cfg = 0;
    logic [31:0] m_pv [4];
    bit          e_ack = 0;
    logic [31:0] e_rd = 0;

    mac_srst_ctl #(.DATA_W(32), .ADDR_W(4), .PRESV_N(4), .TX_W(8), .RST_CYCLES(RST)) uut (
        .clk(clk), .rst_n(rst_n), .unit_disable_i(dis), .bus_idle_i(idle),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_ack_o(ack), .bus_rdata_o(rdata), .reload_req_o(rel_req),
        .reload_done_i(done_in), .reload_data_i(rl_data), .int_rst_o(int_rst),
        .clk_en_o(clk_en), .tx_data_i(tx_in), .tx_data_o(tx_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin : model
        bit acc, take, enter, start;
        logic [31:0] rv;
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_seen = 0; m_ctrl = 0; m_cfg = 0;
            for (int i = 0; i < 4; i++) m_pv[i] = 0;
            e_ack = 0; e_rd = 0;
        end else begin
            acc   = req && !dis && (m_st < 2);
            take  = (m_st == 2 || m_st == 3) && !m_seen && !dis && done_in;
            rv    = (addr == 0) ? m_ctrl : (addr == 1) ? m_cfg :
                    (addr >= 2 && addr < 6) ? m_pv[addr-2] : 32'h0;
            e_ack = acc;
            e_rd  = (acc && !we) ? rv : 32'h0;
            start = acc && we && addr == 0 && wdata[0] && m_st == 0;
            if (acc && we && addr >= 2 && addr < 6) m_pv[addr-2] = wdata;
            if (dis) begin
                m_ctrl = 0; m_cfg = 0; m_st = 0; m_seen = 0; m_tmr = 0;
            end else begin
                enter = (m_st == 1) && idle;
                if (enter) m_ctrl = m_ctrl & 32'h1;
                else if (m_st == 4) m_ctrl[0] = 1'b0;
                else if (acc && we && addr == 0) m_ctrl = {wdata[31:1], m_ctrl[0] | start};
                if (enter) m_cfg = 0;
                else if (take) m_cfg = rl_data;
                else if (acc && we && addr == 1) m_cfg = wdata;
                case (m_st)
                    0: if (start) m_st = 1;
                    1: if (enter) begin m_st = 2; m_tmr = RST; m_seen = 0; end
                    2: begin
                        m_tmr--;
                        if (take) m_seen = 1;
                        if (m_tmr == 0) m_st = m_seen ? 4 : 3;
                    end
                    3: if (take) m_st = 4;
                    default: m_st = 0;
                endcase
            end
        end
    end

    // Compare against the model on every falling edge; also measure pulse length.
    always @(negedge clk) begin : compare
        bit ei;
        if (rst_n) begin
            ei = dis || m_st == 2 || m_st == 3;
            chk(int_rst === ei, "R2 int_rst", 32'(int_rst), 32'(ei));
            chk(rel_req === (!dis && (m_st == 2 || m_st == 3) && !m_seen), "R3 reload_req",
                32'(rel_req), 32'(!dis && (m_st == 2 || m_st == 3) && !m_seen));
            chk(ack === e_ack, "R5 ack", 32'(ack), 32'(e_ack));
            chk(rdata === e_rd, "R11 rdata", rdata, e_rd);
            chk(tx_out === (ei ? 8'h0 : tx_in), "R7 tx", 32'(tx_out), 32'(ei ? 8'h0 : tx_in));
            chk(clk_en === !dis, "R10 clk_en", 32'(clk_en), 32'(!dis));
        end
        if (int_rst && !dis) cur_len++;
        else if (cur_len != 0) begin last_len = cur_len; cur_len = 0; end
        tx_in <= tx_in + 8'd7;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req <= 1; we <= 1; addr <= a; wdata <= d;
        @(negedge clk);
        req <= 0; we <= 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req <= 1; we <= 0; addr <= a;
        @(negedge clk);
        req <= 0;
        chk(ack === 1'b1 && rdata === exp, tag, rdata, exp);
    endtask

    task automatic rd_blocked(input logic [3:0] a, input string tag);
        @(negedge clk);
        req <= 1; we <= 0; addr <= a;
        @(negedge clk);
        req <= 0;
        chk(ack === 1'b0, tag, 32'(ack), 32'h0);
    endtask

    task automatic pulse_done(input logic [31:0] d);
        @(negedge clk);
        done_in <= 1; rl_data <= d;
        @(negedge clk);
        done_in <= 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n <= 1;
        // R9: everything zero after power-on
        rd(0, 0, "R9 ctrl after por");
        rd(1, 0, "R9 cfg after por");
        rd(2, 0, "R9 preserved after por");
        // R11: write/read, unmapped reads zero
        for (int i = 0; i < 4; i++) wr(4'(2 + i), 32'hC0DE_0000 + i);
        wr(1, 32'h1111_2222);
        wr(0, 32'hA5A5_0000);
        rd(3, 32'hC0DE_0001, "R11 preserved readback");
        rd(1, 32'h1111_2222, "R11 cfg readback");
        rd(9, 0, "R11 unmapped read");
        // R1: request while bus busy does not reset
        wr(0, 32'hA5A5_0001);
        repeat (10) @(negedge clk);
        chk(int_rst === 1'b0, "R1 held off while bus busy", 32'(int_rst), 0);
        rd(0, 32'hA5A5_0001, "R6 bit0 pending");
        wr(0, 32'hA5A5_0000);
        rd(0, 32'hA5A5_0001, "R6 write 0 does not cancel");
        wr(0, 32'hA5A5_0001);
        // R2/R3: reset with reload inside window
        idle <= 1;
        repeat (3) @(negedge clk);
        chk(rel_req === 1'b1, "R3 reload requested", 32'(rel_req), 1);
        rd_blocked(2, "R5 read ignored in reset");
        @(negedge clk); req <= 1; we <= 1; addr <= 2; wdata <= 32'hDEAD_BEEF;
        @(negedge clk); req <= 0; we <= 0;
        chk(ack === 1'b0, "R5 write not acked", 32'(ack), 0);
        pulse_done(32'h0000_1234);
        wait (!int_rst);
        repeat (3) @(negedge clk);
        chk(last_len == RST, "R2 window length", last_len, RST);
        rd(0, 0, "R6/R8 ctrl cleared after reset");
        rd(1, 32'h0000_1234, "R3 cfg from reload");
        rd(2, 32'hC0DE_0000, "R8 preserved kept");
        rd(5, 32'hC0DE_0003, "R8 preserved kept top");
        // R4: late reload extends the reset
        wr(0, 32'h1);
        repeat (RST + 8) @(negedge clk);
        done_in <= 1; rl_data <= 32'h0000_5678;
        @(negedge clk); done_in <= 0;
        repeat (3) @(negedge clk);
        chk(last_len == RST + 8, "R4 held for late reload", last_len, RST + 8);
        rd(1, 32'h0000_5678, "R4 cfg from late reload");
        // R10: disable while a request waits for the bus
        idle <= 0;
        wr(0, 32'hF0F0_0001);
        @(negedge clk); dis <= 1;
        @(negedge clk);
        chk(clk_en === 1'b0 && int_rst === 1'b1, "R10 disable gates", 32'({clk_en, int_rst}), 32'h1);
        rd_blocked(0, "R10 bus deaf while disabled");
        repeat (3) @(negedge clk);
        dis <= 0;
        rd(0, 0, "R10 ctrl cleared by disable");
        rd(1, 0, "R10 cfg cleared by disable");
        rd(4, 32'hC0DE_0002, "R10 preserved kept");
        idle <= 1;
        repeat (5) @(negedge clk);
        chk(int_rst === 1'b0, "R10 pending reset dropped", 32'(int_rst), 0);
        // R9: power-on reset clears preserved set
        rst_n <= 0;
        repeat (3) @(negedge clk);
        rst_n <= 1;
        rd(2, 0, "R9 preserved cleared by por");
        rd(5, 0, "R9 preserved top cleared by por");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule